// File: doc/BRIEF.md
# Integer ALU with Trap-Selectable Arithmetic

This combinational execute unit sits in the integer pipe of a small RISC-style core. It takes two register operands, a short immediate, an operation code and a flag that substitutes the immediate for the second operand. It returns a full-width result and a request that goes high when a trapping arithmetic operation overflows. Immediate extension happens inside the block. Signed and unsigned forms are chosen per operation. Exception sequencing, operand fetch and instruction decode sit outside it.

Each add and subtract has two forms. The trapping form flags two's-complement overflow. The wrapping form returns the same bits and never flags. The add and compare operations extend their immediate by sign, and this includes the unsigned-named forms. The bitwise operations pad their immediate with zeros. Shifts are logical, and the shift amount has ceil(log2(WIDTH)) bits.

Top module: `trap_alu`

## Requirements
- R1: Opcode 1 (wrapping add) returns (A + B) mod 2^WIDTH, and ovf_trap stays 0 for it whatever the operands.
- R2: Opcode 3 (wrapping subtract) returns (A - B) mod 2^WIDTH, and ovf_trap stays 0 for it.
- R3: Opcode 0 (trapping add) returns the same sum as opcode 1. It raises ovf_trap when both operands have the same sign bit and the result's sign bit differs from theirs. Operands of differing sign never raise it.
- R4: Opcode 2 (trapping subtract) returns A - B. It raises ovf_trap when A and B differ in sign and the result's sign differs from A's sign. Operands of equal sign never raise it.
- R5: Opcodes 4 (AND) and 5 (OR) are bitwise. With imm_sel = 1 their second operand is the immediate padded with zeros above bit IMM_W-1.
- R6: With imm_sel = 1, opcodes 0, 1, 6 and 7 use the immediate with bit IMM_W-1 copied into every higher bit as their second operand.
- R7: Opcode 6 (signed less-than) returns 1 when A < B as two's-complement numbers and 0 otherwise. All bits above bit 0 are zero.
- R8: Opcode 7 (unsigned less-than) returns 1 when A < B as unsigned magnitudes and 0 otherwise.
- R9: Opcode 8 shifts A left by shamt and fills the vacated low bits with zeros.
- R10: Opcode 9 shifts A right by shamt and fills the vacated high bits with zeros.
- R11: ovf_trap is 0 for every opcode except 0 and 2. Opcodes 10 to 15 return a zero result.
- R12: imm_sel has no effect on opcodes 2, 3, 8 and 9. They always use opnd_b as their second operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First register operand |
| opnd_b | input | WIDTH | Second register operand |
| imm | input | IMM_W | Immediate field |
| imm_sel | input | 1 | Use the extended immediate in place of opnd_b |
| op | input | 4 | Operation code |
| shamt | input | ceil(log2(WIDTH)) | Shift amount |
| result | output | WIDTH | Operation result |
| ovf_trap | output | 1 | Overflow trap request |

## Verification
The embedded checks are tested on every input change. They cover four properties: only the two trapping opcodes can raise the trap, add operands of differing sign and subtract operands of equal sign never overflow, comparison results are confined to bit 0, and zero-padded immediates and shift fills carry no ones. The result values themselves can only be shown by the bench scenarios. These include signed against unsigned ordering, the sign-extension choice per opcode, the overflow corners at the most positive and most negative values, negation of the most negative value, and the fact that imm_sel is ignored by subtract and shift. The bench sweeps every operand pair on a narrow instance and runs directed corners on a full-width one.

// File: rtl/alu_pkg.sv
// Package: operation codes and per-opcode decode helpers for trap_alu.
// Assumes: the opcode field is four bits wide; codes 10..15 are unused.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_SLT  = 4'd6,
        OP_SLTU = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9
    } alu_op_e;

    // True when the opcode may take the immediate as its second operand.
    function automatic logic op_takes_imm(alu_op_e op);
        return op inside {OP_ADD, OP_ADDU, OP_AND, OP_OR, OP_SLT, OP_SLTU};
    endfunction

    // True when the immediate is extended by sign rather than by zeros.
    function automatic logic op_sign_imm(alu_op_e op);
        return op inside {OP_ADD, OP_ADDU, OP_SLT, OP_SLTU};
    endfunction

endpackage

// File: rtl/imm_extend.sv
// Module: widens the immediate field to the datapath width.
// Assumes: WIDTH > IMM_W; sign_ext selects top-bit replication, else zeros.
module imm_extend #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm,
    input  logic             sign_ext,
    output logic [WIDTH-1:0] ext_out
);
    localparam int PAD_W = WIDTH - IMM_W;

    logic [PAD_W-1:0] pad;

    // Choose the fill for the upper bits.
    always_comb begin
        pad     = sign_ext ? {PAD_W{imm[IMM_W-1]}} : '0;
        ext_out = {pad, imm};
    end

    // Zero padding must leave no ones above the field.
    always_comb begin
        AST_ZERO_EXT: assert (sign_ext || ext_out[WIDTH-1:IMM_W] == '0); // R5
    end

endmodule

// File: rtl/add_sub.sv
// Module: shared adder for add and subtract with two's-complement overflow.
// Assumes: sub = 1 computes a - b as a + ~b + 1; ovf is raw, not gated by opcode.
module add_sub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_in;

    // Invert the second operand and inject the carry for subtraction.
    always_comb begin
        b_in = sub ? ~b : b;
        sum  = a + b_in + {{(WIDTH-1){1'b0}}, sub};
        ovf  = (a[MSB] == b_in[MSB]) && (sum[MSB] != a[MSB]);
    end

    // Differing signs on add, or equal signs on subtract, cannot overflow.
    always_comb begin
        AST_NO_OVERFLOW: assert (sub || a[MSB] == b[MSB] || !ovf); // R3
        AST_SUB_SAME_SIGN: assert (!sub || a[MSB] != b[MSB] || !ovf); // R4
    end

endmodule

// File: rtl/set_compare.sv
// Module: less-than comparison, signed or unsigned by select.
// Assumes: uns = 1 compares magnitudes, uns = 0 compares two's complement.
module set_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             uns,
    output logic             lt
);
    // Pick the comparison domain.
    always_comb begin
        if (uns) lt = (a < b);
        else     lt = ($signed(a) < $signed(b));
    end

endmodule

// File: rtl/log_shifter.sv
// Module: logarithmic zero-fill shifter for both directions.
// Assumes: left shifts reuse the right-shift stages by reversing bit order.
module log_shifter #(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = 5
) (
    input  logic [WIDTH-1:0]   din,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               left,
    output logic [WIDTH-1:0]   dout
);
    logic [WIDTH-1:0] din_rev;
    logic [WIDTH-1:0] stage [0:SHAMT_W];
    logic [WIDTH-1:0] out_rev;

    // Reverse input and output bit order.
    for (genvar k = 0; k < WIDTH; k++) begin : g_rev
        assign din_rev[k] = din[WIDTH-1-k];
        assign out_rev[k] = stage[SHAMT_W][WIDTH-1-k];
    end

    assign stage[0] = left ? din_rev : din;

    // One stage per shift-amount bit, each moving by a power of two.
    for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
        assign stage[i+1] = amt[i] ? (stage[i] >> (2**i)) : stage[i];
    end

    assign dout = left ? out_rev : stage[SHAMT_W];

    // Any non-zero shift empties the edge bit it moves away from.
    always_comb begin
        AST_SLL_FILL: assert (!left || amt == '0 || !dout[0]); // R9
        AST_SRL_FILL: assert (left || amt == '0 || !dout[WIDTH-1]); // R10
    end

endmodule

// File: rtl/trap_alu.sv
// Module: top of the integer execute unit; picks operands, steers units, gates trap.
// Assumes: purely combinational, no clock or reset; WIDTH a power of two above IMM_W.
module trap_alu #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16,
    localparam int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic [IMM_W-1:0]   imm,
    input  logic               imm_sel,
    input  logic [3:0]         op,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [WIDTH-1:0]   result,
    output logic               ovf_trap
);
    import alu_pkg::*;

    alu_op_e          op_e;
    logic             sign_imm;
    logic [WIDTH-1:0] imm_ext;
    logic [WIDTH-1:0] b_eff;
    logic             is_sub;
    logic [WIDTH-1:0] arith;
    logic             arith_ovf;
    logic             lt;
    logic [WIDTH-1:0] shifted;

    assign op_e     = alu_op_e'(op);
    assign sign_imm = op_sign_imm(op_e);

    imm_extend #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_ext (
        .imm      (imm),
        .sign_ext (sign_imm),
        .ext_out  (imm_ext)
    );

    // Select the second operand: immediate only where the opcode allows it.
    always_comb begin
        b_eff  = (imm_sel && op_takes_imm(op_e)) ? imm_ext : opnd_b;
        is_sub = (op_e == OP_SUB) || (op_e == OP_SUBU);
    end

    add_sub #(.WIDTH(WIDTH)) u_arith (
        .a   (opnd_a),
        .b   (b_eff),
        .sub (is_sub),
        .sum (arith),
        .ovf (arith_ovf)
    );

    set_compare #(.WIDTH(WIDTH)) u_cmp (
        .a   (opnd_a),
        .b   (b_eff),
        .uns (op_e == OP_SLTU),
        .lt  (lt)
    );

    log_shifter #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
        .din  (opnd_a),
        .amt  (shamt),
        .left (op_e == OP_SLL),
        .dout (shifted)
    );

    // Route the unit output for the opcode and gate the trap request.
    always_comb begin
        unique case (op_e)
            OP_ADD, OP_ADDU,
            OP_SUB, OP_SUBU: result = arith;
            OP_AND:          result = opnd_a & b_eff;
            OP_OR:           result = opnd_a | b_eff;
            OP_SLT, OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt};
            OP_SLL, OP_SRL:  result = shifted;
            default:         result = '0;
        endcase
        ovf_trap = ((op_e == OP_ADD) || (op_e == OP_SUB)) && arith_ovf;
    end

    // Trap scope and compare-result shape.
    always_comb begin
        AST_TRAP_SCOPE: assert (!ovf_trap || op == 4'd0 || op == 4'd2); // R11
        AST_SLT_BOOL: assert (!(op == 4'd6 || op == 4'd7) || result[WIDTH-1:1] == '0); // R7
    end

endmodule

// File: tb/test_trap_alu.sv
// Bench: exhaustive sweep of a narrow instance plus full-width corner cases.
module test_trap_alu;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 8;
    localparam int SI = 4;

    logic clk = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Full-width instance.
    logic [31:0] w_a, w_b, w_res;
    logic [15:0] w_imm;
    logic        w_isel, w_trap;
    logic [3:0]  w_op;
    logic [4:0]  w_sh;

    trap_alu i_trap_alu (
        .opnd_a(w_a), .opnd_b(w_b), .imm(w_imm), .imm_sel(w_isel),
        .op(w_op), .shamt(w_sh), .result(w_res), .ovf_trap(w_trap)
    );

    // Narrow instance for the exhaustive sweep.
    logic [SW-1:0] s_a, s_b, s_res;
    logic [SI-1:0] s_imm;
    logic          s_isel, s_trap;
    logic [3:0]    s_op;
    logic [2:0]    s_sh;

    trap_alu #(.WIDTH(SW), .IMM_W(SI)) i_trap_alu_small (
        .opnd_a(s_a), .opnd_b(s_b), .imm(s_imm), .imm_sel(s_isel),
        .op(s_op), .shamt(s_sh), .result(s_res), .ovf_trap(s_trap)
    );

    // Arithmetic reference model; returns {trap, result}.
    function automatic logic [32:0] ref_alu(int w, int iw, int op,
            longint unsigned a, longint unsigned b, longint unsigned im,
            bit isel, int sh);
        longint unsigned mask = (64'd1 << w) - 1;
        longint unsigned msb  = 64'd1 << (w - 1);
        longint unsigned sx, bb, r;
        longint sa, sb;
        bit t = 1'b0;
        bit ov;
        sx = (im & (64'd1 << (iw - 1))) != 0 ? (im | (mask & ~((64'd1 << iw) - 1))) : im;
        if (isel && op inside {0, 1, 4, 5, 6, 7})
            bb = (op inside {0, 1, 6, 7}) ? sx : im;
        else
            bb = b;
        r = 0;
        case (op)
            0, 1: begin
                r  = (a + bb) & mask;
                ov = ((a & msb) == (bb & msb)) && ((r & msb) != (a & msb));
                t  = (op == 0) && ov;
            end
            2, 3: begin
                r  = (a - bb) & mask;
                ov = ((a & msb) != (bb & msb)) && ((r & msb) != (a & msb));
                t  = (op == 2) && ov;
            end
            4: r = a & bb;
            5: r = a | bb;
            6: begin
                sa = (a & msb) != 0 ? longint'(a) - longint'(mask) - 1 : longint'(a);
                sb = (bb & msb) != 0 ? longint'(bb) - longint'(mask) - 1 : longint'(bb);
                r  = (sa < sb) ? 1 : 0;
            end
            7: r = (a < bb) ? 1 : 0;
            8: r = (a << sh) & mask;
            9: r = a >> sh;
            default: r = 0;
        endcase
        return {t, r[31:0]};
    endfunction

    // Requirement tag for a swept vector.
    function automatic string req_of(int op, bit isel);
        if (isel && op inside {0, 1, 6, 7}) return "R6";
        if (isel && op inside {2, 3, 8, 9}) return "R12";
        case (op)
            0: return "R3";
            1: return "R1";
            2: return "R4";
            3: return "R2";
            4, 5: return "R5";
            6: return "R7";
            7: return "R8";
            8: return "R9";
            9: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Compare one result/trap pair and report a mismatch.
    task automatic check(string req, logic [31:0] got_r, logic got_t,
                         logic [31:0] exp_r, logic exp_t);
        n_chk++;
        if (got_r !== exp_r || got_t !== exp_t) begin
            n_fail++;
            $display("FAIL %s: got result=%h trap=%b, expected result=%h trap=%b",
                     req, got_r, got_t, exp_r, exp_t);
        end
    endtask

    // Drive the full-width instance and check against literal values.
    task automatic wide(string req, int op, logic [31:0] a, logic [31:0] b,
                        logic [15:0] im, bit isel, logic [4:0] sh,
                        logic [31:0] exp_r, logic exp_t);
        w_op = op[3:0]; w_a = a; w_b = b; w_imm = im; w_isel = isel; w_sh = sh;
        #1;
        check(req, w_res, w_trap, exp_r, exp_t);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        logic [32:0] e;
        w_op = 4'd0; w_a = '0; w_b = '0; w_imm = '0; w_isel = 1'b0; w_sh = '0;
        s_op = 4'd0; s_a = '0; s_b = '0; s_imm = '0; s_isel = 1'b0; s_sh = '0;
        #(CLK_PERIOD/2 + 1);

        // Initial all-zero inputs: zero sum, no trap (R1, R3).
        check("R3", w_res, w_trap, 32'h0, 1'b0);

        // Full-width corners.
        wide("R3", 0, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 32'h80000000, 1'b1);
        wide("R1", 1, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 32'h80000000, 1'b0);
        wide("R4", 2, 32'h80000000, 32'h1, 16'h0, 0, 0, 32'h7FFFFFFF, 1'b1);
        wide("R2", 3, 32'h80000000, 32'h1, 16'h0, 0, 0, 32'h7FFFFFFF, 1'b0);
        wide("R4", 2, 32'h0, 32'h80000000, 16'h0, 0, 0, 32'h80000000, 1'b1);
        wide("R3", 0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 0, 0, 32'hFFFFFFFF, 1'b0);
        wide("R7", 6, 32'hFFFFFFFC, 32'd1000000000, 16'h0, 0, 0, 32'h1, 1'b0);
        wide("R8", 7, 32'hFFFFFFFC, 32'd1000000000, 16'h0, 0, 0, 32'h0, 1'b0);
        wide("R6", 0, 32'h4, 32'h0, 16'hFFFC, 1, 0, 32'h0, 1'b0);
        wide("R6", 7, 32'h5, 32'h0, 16'hFFFF, 1, 0, 32'h1, 1'b0);
        wide("R5", 4, 32'hFFFFFFFF, 32'h0, 16'hFFFC, 1, 0, 32'h0000FFFC, 1'b0);
        wide("R5", 5, 32'h12340000, 32'h0, 16'h8001, 1, 0, 32'h12348001, 1'b0);
        wide("R9", 8, 32'h0000000D, 32'h0, 16'h0, 0, 8, 32'h00000D00, 1'b0);
        wide("R10", 9, 32'h80000000, 32'h0, 16'h0, 0, 31, 32'h00000001, 1'b0);
        wide("R12", 2, 32'h10, 32'h3, 16'hFFFF, 1, 0, 32'h0000000D, 1'b0);
        wide("R11", 12, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 32'h0, 1'b0);

        // Exhaustive operand sweep on the narrow instance, register operand.
        s_isel = 1'b0;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    s_op = op[3:0]; s_a = a[7:0]; s_b = b[7:0]; s_sh = b[2:0];
                    s_imm = a[3:0];
                    #1;
                    e = ref_alu(SW, SI, op, a, b, a & 15, 1'b0, b & 7);
                    check(req_of(op, 1'b0), {24'h0, s_res}, s_trap, e[31:0], e[32]);
                end
            end
        end

        // Immediate sweep: every immediate against every first operand.
        s_isel = 1'b1;
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int im = 0; im < 16; im++) begin
                    s_op = op[3:0]; s_a = a[7:0]; s_imm = im[3:0];
                    s_b = 8'(a ^ 8'h5A ^ im); s_sh = 3'(im);
                    #1;
                    e = ref_alu(SW, SI, op, a, (a ^ 8'h5A ^ im) & 255, im, 1'b1, im & 7);
                    check(req_of(op, 1'b1), {24'h0, s_res}, s_trap, e[31:0], e[32]);
                end
            end
        end

        finish_run();
    end

endmodule